// File: doc/BRIEF.md
# Key-Locked Reset Watchdog

This block is a countdown watchdog meant to sit inside a power-management device, where its expiry can pull a system-wide reset. Software reaches it through a small register port. Three gates stand between a stray write and an armed timer:

- a module-enable bit, which opens the register port itself;
- a clock-enable bit, which lets the counter advance;
- a lock register, which must hold a magic key before the load and control registers take new values.

The reload value is 32 bits wide and is split over two 16-bit registers. The counter steps down on a slow tick input, for example a strobe at 32.768 kHz. When it expires with reset enabled, the block emits a fixed-length reset pulse.

Register writes complete in the cycle they are presented. A read returns its data with `rvalid` one clock later. The read response has no ready signal and cannot be back-pressured, so the requester must accept it in that cycle. `tick` and `rst_out` are plain level pins.

Top module: `wdg_keylock`

## Requirements
- R1: After reset the block is locked, the module and clock enables are clear, the load and control registers hold zero, and `rst_out` and `rvalid` are low.
- R2: A read presented with `rd_en` returns its data on `rdata` with `rvalid` high exactly one clock later. The load and control registers read back their contents whether the block is locked or unlocked.
- R3: Writing 0xE551 to the lock register at byte offset 0xA0 unlocks the block. While unlocked, reading the lock register returns 0x0001; while locked, it returns 0x0000.
- R4: Writing any other value to the lock register relocks the block. While locked, writes to the load and control registers leave them unchanged.
- R5: The load-low register at 0x80 holds count bits 15:0. The load-high register at 0x84 holds count bits 31:16.
- R6: The control register at 0x88 keeps only bit 1 (run) and bit 3 (reset enable). All other bits read as zero.
- R7: Bit 2 of the module-enable register at 0x90 is always writable. While it is clear, writes to every other register are ignored, reads of every other register return zero, and the counter does not advance.
- R8: Bit 2 of the clock-enable register at 0x94 must be set for the counter to step on `tick`. While it is clear, ticks are not counted.
- R9: A rising run bit loads the counter from the load registers. Each counted tick decrements the counter. A counted tick that finds the counter at zero is an expiry and reloads the counter, so a load value of N expires on the (N+1)th counted tick.
- R10: An expiry with reset enable set drives `rst_out` high for exactly RST_CYCLES clocks, starting on the clock after the expiring tick. An expiry with reset enable clear produces no pulse.
- R11: While run is clear the counter neither counts nor expires, whatever the tick input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| tick | input | 1 | Counting strobe, one clock wide per tick |
| rdata | output | 16 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read response valid, one clock after `rd_en` |
| rst_out | output | 1 | System reset pulse |

## Verification
Read data is due one clock after `rd_en`. The bench's driver queues the expected word when it issues the read, and a monitor pops the queue on the falling edge after `rvalid` rises. A write takes effect at the edge on which it is presented. A run rise loads the counter at the next edge. `rst_out` rises on the edge after the expiring tick. The bench therefore places each tick between falling edges and samples `rst_out` on the falling edge that follows it. It then counts the pulse length over the following falling edges. The tick counts before expiry and the silent windows with the gates closed are compared against the number of ticks applied.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 16;

  localparam logic [ADDR_W-1:0] A_LOAD_LO = 8'h80;
  localparam logic [ADDR_W-1:0] A_LOAD_HI = 8'h84;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h88;
  localparam logic [ADDR_W-1:0] A_MOD_EN  = 8'h90;
  localparam logic [ADDR_W-1:0] A_CLK_EN  = 8'h94;
  localparam logic [ADDR_W-1:0] A_LOCK    = 8'hA0;

  localparam logic [REG_W-1:0] UNLOCK_KEY = 16'hE551;

  localparam int RUN_BIT   = 1;
  localparam int RSTEN_BIT = 3;
  localparam int GATE_BIT  = 2;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              rvalid,
  output logic [CNT_W-1:0]  load_val,
  output logic              run,
  output logic              rst_en,
  output logic              clk_on,
  output logic              unlocked
);
  localparam int HI_W = CNT_W - REG_W;

  logic             mod_en_r, clk_en_r;
  logic [REG_W-1:0] load_lo;
  logic [HI_W-1:0]  load_hi;
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_en_r <= 1'b0;
      clk_en_r <= 1'b0;
      unlocked <= 1'b0;
      load_lo  <= '0;
      load_hi  <= '0;
      run      <= 1'b0;
      rst_en   <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_MOD_EN) begin
        mod_en_r <= wdata[GATE_BIT];
      end else if (mod_en_r) begin
        case (addr)
          A_CLK_EN:  clk_en_r <= wdata[GATE_BIT];
          A_LOCK:    unlocked <= (wdata == UNLOCK_KEY);
          A_LOAD_LO: if (unlocked) load_lo <= wdata;
          A_LOAD_HI: if (unlocked) load_hi <= wdata[HI_W-1:0];
          A_CTRL: if (unlocked) begin
            run    <= wdata[RUN_BIT];
            rst_en <= wdata[RSTEN_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_MOD_EN:  rd_mux[GATE_BIT] = mod_en_r;
      A_CLK_EN:  rd_mux[GATE_BIT] = clk_en_r;
      A_LOCK:    rd_mux[0] = unlocked;
      A_LOAD_LO: rd_mux = load_lo;
      A_LOAD_HI: rd_mux = REG_W'(load_hi);
      A_CTRL: begin
        rd_mux[RUN_BIT]   = run;
        rd_mux[RSTEN_BIT] = rst_en;
      end
      default: rd_mux = '0;
    endcase
    if (!mod_en_r && addr != A_MOD_EN) rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign load_val = {load_hi, load_lo};
  assign clk_on   = mod_en_r & clk_en_r;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clk_on,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  logic run_d;
  logic start, advance;

  assign start   = run & ~run_d;
  assign advance = run & clk_on & tick;
  assign fire    = advance & ~start & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d <= 1'b0;
      count <= '0;
    end else begin
      run_d <= run;
      if (start)            count <= load_val;
      else if (fire)        count <= load_val;
      else if (advance)     count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic rst_en,
  output logic rst_out
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (fire && rst_en) left <= PW'(RST_CYCLES);
    else if (left != '0)     left <= left - 1'b1;
  end

  assign rst_out = (left != '0);
endmodule

// File: rtl/wdg_keylock.sv
module wdg_keylock
  import wdg_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              tick,
  output logic [REG_W-1:0]  rdata,
  output logic              rvalid,
  output logic              rst_out
);
  logic [CNT_W-1:0] load_val, count;
  logic run, rst_en, clk_on, unlocked, fire;

  wdg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .load_val(load_val), .run(run), .rst_en(rst_en),
    .clk_on(clk_on), .unlocked(unlocked)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .clk_on(clk_on), .load_val(load_val), .count(count), .fire(fire)
  );

  wdg_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rst_en(rst_en),
    .rst_out(rst_out)
  );
endmodule

// File: rtl/wdg_keylock_chk.sv
module wdg_keylock_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             rvalid,
  input logic             unlocked,
  input logic [CNT_W-1:0] load_val,
  input logic             run,
  input logic             rst_en,
  input logic             clk_on,
  input logic [CNT_W-1:0] count,
  input logic             rst_out
);
  // R2
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_en));

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(load_val) && $stable(run) && $stable(rst_en)));

  // R10
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(rst_en));

  // R8
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && run && $past(run)) |=> $stable(count));

  // R11
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));
endmodule

bind wdg_keylock wdg_keylock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rvalid(rvalid),
  .unlocked(unlocked), .load_val(load_val), .run(run), .rst_en(rst_en),
  .clk_on(clk_on), .count(count), .rst_out(rst_out)
);

// File: tb/test_wdg_keylock.sv
`timescale 1ns/1ps
module test_wdg_keylock;
  localparam int RST_CYCLES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid, rst_out;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  wdg_keylock #(.CNT_W(32), .RST_CYCLES(RST_CYCLES)) i_wdg_keylock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tick(tick), .rdata(rdata), .rvalid(rvalid),
    .rst_out(rst_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  // monitor: rvalid rises one edge after rd_en, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected rvalid", 1, 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
  end

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // apply n ticks; rst_out must stay low after each
  task automatic quiet_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick_once();
      check(rst_out == 1'b0, tag, rst_out, 0);
    end
  endtask

  task automatic expect_pulse(input string tag);
    int len = 0;
    check(rst_out == 1'b1, tag, rst_out, 1);
    while (rst_out && len < 50) begin len++; @(negedge clk); end
    check(len == RST_CYCLES, {tag, " pulse length"}, len, RST_CYCLES);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rst_out == 1'b0, "R1 rst_out low", rst_out, 0);
    check(rvalid == 1'b0, "R1 rvalid low", rvalid, 0);
    rst_n = 1'b1;
    rd(8'h90, 16'h0000, "R1 module enable clear");
    // R7 writes ignored while module disabled
    wr(8'hA0, 16'hE551);
    wr(8'h90, 16'h0004);
    rd(8'h90, 16'h0004, "R7 module enable set");
    rd(8'hA0, 16'h0000, "R7 key ignored when disabled / R1 locked");
    rd(8'h88, 16'h0000, "R1 control zero");
    // R4 locked writes ignored
    wr(8'h80, 16'h1234);
    rd(8'h80, 16'h0000, "R4 load ignored while locked");
    // R3 unlock
    wr(8'hA0, 16'hE551);
    rd(8'hA0, 16'h0001, "R3 unlocked");
    // R5 split load
    wr(8'h84, 16'hABCD);
    wr(8'h80, 16'h0003);
    rd(8'h84, 16'hABCD, "R5 load high");
    rd(8'h80, 16'h0003, "R5 load low");
    wr(8'h84, 16'h0000);
    // R6 control bit mask
    wr(8'h88, 16'hFFFF);
    rd(8'h88, 16'h000A, "R6 control keeps run and reset enable");
    wr(8'h88, 16'h0000);
    // R4 relock with wrong key
    wr(8'hA0, 16'h1111);
    rd(8'hA0, 16'h0000, "R4 relocked");
    wr(8'h88, 16'h000A);
    rd(8'h88, 16'h0000, "R4 control ignored while locked");
    rd(8'h80, 16'h0003, "R2 load readable while locked");
    // arm: load 3, clock on, run + reset enable
    wr(8'hA0, 16'hE551);
    wr(8'h94, 16'h0004);
    wr(8'h88, 16'h000A);
    // R9 expiry on fourth tick
    quiet_ticks(3, "R9 no expiry before tick N+1");
    tick_once();
    expect_pulse("R10 expiry pulse");
    // R8 clock enable cleared: ticks not counted
    wr(8'h94, 16'h0000);
    quiet_ticks(6, "R8 clock gated");
    wr(8'h94, 16'h0004);
    quiet_ticks(3, "R8 count held while gated");
    tick_once();
    expect_pulse("R8 expiry after ungating");
    // R10 no pulse without reset enable (counter reloaded to 3)
    wr(8'h88, 16'h0002);
    quiet_ticks(4, "R10 no pulse when reset disabled");
    repeat (RST_CYCLES + 2) begin
      @(negedge clk);
      check(rst_out == 1'b0, "R10 stays low", rst_out, 0);
    end
    // R11 run cleared: no counting
    wr(8'h88, 16'h0000);
    quiet_ticks(8, "R11 halted when run clear");
    wr(8'h88, 16'h000A);
    quiet_ticks(3, "R9 reload on run rise");
    tick_once();
    expect_pulse("R9 expiry after reload");
    // R7 module disable hides reads, state kept
    wr(8'h90, 16'h0000);
    rd(8'h88, 16'h0000, "R7 reads zero when disabled");
    wr(8'h90, 16'h0004);
    rd(8'h88, 16'h000A, "R7 control kept");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule